// File: doc/BRIEF.md
# Loadable Odd-Step Up/Down Counter

This block is a fully synchronous nine-bit counter. A two-bit operation code picks one of four actions on every rising clock edge. LOAD copies an external nine-bit value into the count. UP adds three. DOWN subtracts five. HOLD keeps the count as it is. Both arithmetic steps wrap modulo 512.

Alongside the count the block drives three more outputs. A carry flag marks the cycle after an up-step that went past 511. A borrow flag marks the cycle after a down-step that went below zero. A parity bit makes the count plus parity hold an even number of ones.

A synchronous, active-high reset returns everything to zero. The block has no asynchronous path. The four operations act as the states of a one-step machine, and the code on `mode` selects the transition on each edge:

- RESET → zero
- LOAD → data
- UP → +3
- DOWN → −5
- HOLD → same

Top module: `oddstep_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next `count` is 0, `carry` is 0 and `borrow` is 0 (so `parity` is 0). Reset takes priority over `mode`.
- R2: With `mode` = 2'b00 (LOAD), the next `count` equals `load_data`, and `carry` and `borrow` become 0.
- R3: With `mode` = 2'b01 (UP), the next `count` is (count + 3) mod 512.
- R4: With `mode` = 2'b10 (DOWN), the next `count` is (count − 5) mod 512.
- R5: With `mode` = 2'b11 (HOLD), `count` is unchanged and `carry` and `borrow` become 0.
- R6: `carry` is 1 for exactly the cycle after an UP step whose start count was 509 or more. It is 0 after every other step.
- R7: `borrow` is 1 for exactly the cycle after a DOWN step whose start count was 4 or less. It is 0 after every other step.
- R8: `parity` equals the XOR of all nine bits of the current registered `count`.
- R9: `carry` and `borrow` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operation: 00 load, 01 up 3, 10 down 5, 11 hold |
| load_data | input | 9 | Value taken on LOAD |
| count | output | 9 | Registered count |
| carry | output | 1 | Up-step wrapped past 511 on the last edge |
| borrow | output | 1 | Down-step went below 0 on the last edge |
| parity | output | 1 | XOR of the count bits (even parity bit) |

## Verification
The up-step is driven at 508, 509 and 511, which separates the last non-wrapping step from the first wrapping ones. The down-step is driven at 5, 4 and 3, which splits an exact zero result from a borrow. Loads of all-ones and of zero check the parity extremes. Holds placed directly after a wrap show that the flags clear and the count freezes. A long pseudo-random run of mixed codes, with a reset asserted during an UP code, compares every cycle against an independent model. That run catches mis-ordered decode and stale flag state.

// File: rtl/oddstep_pkg.sv
package oddstep_pkg;
    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_HOLD = 2'b11
    } op_e;
endpackage

// File: rtl/oddstep_step.sv
module oddstep_step #(
    parameter int W  = 9,
    parameter int UP = 3,
    parameter int DN = 5
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] inc_val,
    output logic         inc_wrap,
    output logic [W-1:0] dec_val,
    output logic         dec_wrap
);
    localparam logic [W:0] UPV = (W+1)'(UP);
    localparam logic [W:0] DNV = (W+1)'(DN);

    // One spare bit on top captures the wrap out of either end.
    always_comb begin
        {inc_wrap, inc_val} = {1'b0, cur} + UPV;
        {dec_wrap, dec_val} = {1'b0, cur} - DNV;
    end
endmodule

// File: rtl/oddstep_parity.sv
module oddstep_parity #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits,
    output logic         par
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;
    for (genvar gi = 0; gi < W; gi++) begin : g_xor
        assign chain[gi+1] = chain[gi] ^ bits[gi];
    end
    assign par = chain[W];
endmodule

// File: rtl/oddstep_counter.sv
module oddstep_counter #(
    parameter int WIDTH   = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] count,
    output logic             carry,
    output logic             borrow,
    output logic             parity
);
    import oddstep_pkg::*;

    op_e              op;
    logic [WIDTH-1:0] inc_val, dec_val;
    logic             inc_wrap, dec_wrap;

    assign op = op_e'(mode);

    oddstep_step #(.W(WIDTH), .UP(UP_STEP), .DN(DN_STEP)) u_step (
        .cur      (count),
        .inc_val  (inc_val),
        .inc_wrap (inc_wrap),
        .dec_val  (dec_val),
        .dec_wrap (dec_wrap)
    );

    // State register: the operation code selects the transition.
    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            carry  <= 1'b0;
            borrow <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    count  <= load_data;
                    carry  <= 1'b0;
                    borrow <= 1'b0;
                end
                OP_UP: begin
                    count  <= inc_val;
                    carry  <= inc_wrap;
                    borrow <= 1'b0;
                end
                OP_DOWN: begin
                    count  <= dec_val;
                    carry  <= 1'b0;
                    borrow <= dec_wrap;
                end
                OP_HOLD: begin
                    carry  <= 1'b0;
                    borrow <= 1'b0;
                end
            endcase
        end
    end

    // Output process: parity follows the registered count.
    oddstep_parity #(.W(WIDTH)) u_par (
        .bits (count),
        .par  (parity)
    );

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (count == $past(load_data)) && !carry && !borrow);

    a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_UP) |=> count == WIDTH'($past(count) + UP_STEP));

    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DOWN) |=> count == WIDTH'($past(count) - DN_STEP));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(count) && !carry && !borrow);

    a_r6_carry_source: assert property (@(posedge clk) disable iff (rst)
        carry |-> ($past(op) == OP_UP) && (count < WIDTH'(UP_STEP)));

    a_r7_borrow_source: assert property (@(posedge clk) disable iff (rst)
        borrow |-> ($past(op) == OP_DOWN) && (count > ~WIDTH'(DN_STEP)));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(carry && borrow));
endmodule

// File: tb/tb_oddstep_counter.sv
module tb_oddstep_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b11;
    logic [8:0] load_data = '0;
    logic [8:0] count;
    logic       carry, borrow, parity;

    int errors = 0;
    int checks = 0;
    int exp_cnt = 0;
    bit finished = 0;

    typedef struct {
        int    cnt;
        bit    c;
        bit    b;
        bit    p;
        string tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    oddstep_counter dut (
        .clk(clk), .rst(rst), .mode(mode), .load_data(load_data),
        .count(count), .carry(carry), .borrow(borrow), .parity(parity)
    );

    function automatic bit odd_ones(int v);
        int n = 0;
        for (int i = 0; i < 9; i++) n += (v >> i) & 1;
        return bit'(n % 2);
    endfunction

    task automatic apply(bit r, logic [1:0] m, int d, string tag);
        item_t it;
        int    s;
        @(negedge clk);
        rst = r; mode = m; load_data = 9'(d);
        it.c = 0; it.b = 0;
        if (r) exp_cnt = 0;
        else case (m)
            2'b00: exp_cnt = d;
            2'b01: begin s = exp_cnt + 3; it.c = (s > 511); exp_cnt = s % 512; end
            2'b10: begin s = exp_cnt - 5; it.b = (s < 0); exp_cnt = (s + 512) % 512; end
            default: ;
        endcase
        it.cnt = exp_cnt;
        it.p = odd_ones(exp_cnt);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare one expected item per edge, just after the edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            checks++;
            if (count != 9'(e.cnt) || carry != e.c || borrow != e.b || parity != e.p) begin
                errors++;
                $display("FAIL %s: got cnt=%0d c=%0b b=%0b p=%0b exp cnt=%0d c=%0b b=%0b p=%0b",
                         e.tag, count, carry, borrow, parity, e.cnt, e.c, e.b, e.p);
            end
            if (carry && borrow) begin
                errors++;
                $display("FAIL R9: got carry=1 borrow=1 exp not both");
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        apply(1, 2'b01, 0, "R1");
        apply(1, 2'b00, 77, "R1");
        apply(0, 2'b00, 100, "R2");
        apply(0, 2'b01, 0, "R3");
        apply(0, 2'b01, 0, "R3");
        apply(0, 2'b01, 0, "R3");
        apply(0, 2'b10, 0, "R4");
        apply(0, 2'b10, 0, "R4");
        apply(0, 2'b11, 0, "R5");
        apply(0, 2'b11, 0, "R5");
        apply(0, 2'b00, 508, "R2");
        apply(0, 2'b01, 0, "R6");    // 508 -> 511, no carry
        apply(0, 2'b01, 0, "R6");    // 511 -> 2, carry
        apply(0, 2'b11, 0, "R5");    // hold clears carry
        apply(0, 2'b00, 509, "R2");
        apply(0, 2'b01, 0, "R6");    // 509 -> 0, carry
        apply(0, 2'b00, 5, "R2");
        apply(0, 2'b10, 0, "R7");    // 5 -> 0, no borrow
        apply(0, 2'b00, 4, "R2");
        apply(0, 2'b10, 0, "R7");    // 4 -> 511, borrow
        apply(0, 2'b00, 3, "R2");    // load clears borrow
        apply(0, 2'b10, 0, "R7");    // 3 -> 510, borrow
        apply(0, 2'b10, 0, "R7");    // 510 -> 505, no borrow
        apply(0, 2'b00, 511, "R8");  // parity 1
        apply(0, 2'b00, 0, "R8");    // parity 0
        apply(0, 2'b00, 7, "R8");    // parity 1
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k == 200) apply(1, 2'b01, 0, "R1");
            else apply(0, lfsr[1:0], int'(lfsr[12:4]), "R9");
        end
        while (sb.size() > 0) @(posedge clk);
        #3;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule